// File: doc/BRIEF.md
# Header Line Direction Router

This block sits between a host SoC and an external pin header and decides, line by line, how each I/O line behaves. Every line has two control bits taken from register banks. The enable bit either leaves the line high-impedance on both sides or makes it active. The direction bit picks the side that drives: the SoC toward the header, or the header back toward the SoC.

A single global gate input sits above all the per-line settings. While the gate is low, neither side of any line is driven. The routing is purely combinational. A change to a register bit, to the gate or to a data input shows up on the outputs in the same cycle.

The register banks arrive as flat vectors of `NUM_BANKS` banks of `BANK_W` bits. The bank count is derived from the line count. Voltage translation and the serial register access path are outside this block.

Top module: `io_line_router`

## Requirements
- R1: When `route_gate` is 1, a line's enable bit is 1 and its direction bit is 0, `hdr_tx` on that line equals `soc_tx`, `hdr_tx_oe` is 1 and `soc_rx_oe` is 0.
- R2: When `route_gate` is 1, a line's enable bit is 1 and its direction bit is 1, `soc_rx` on that line equals `hdr_rx`, `soc_rx_oe` is 1 and `hdr_tx_oe` is 0.
- R3: When a line's enable bit is 0, both `hdr_tx_oe` and `soc_rx_oe` for that line are 0, whatever its direction bit holds.
- R4: When `route_gate` is 0, every bit of `hdr_tx_oe` and `soc_rx_oe` is 0, whatever the banks hold.
- R5: Line n takes its control from bank n/BANK_W, bit n%BANK_W. In the flat vectors, bank k occupies bits [k*BANK_W+BANK_W-1 : k*BANK_W], so line n uses flat bit n.
- R6: A data output whose output-enable is 0 reads 0. `hdr_tx_oe` and `soc_rx_oe` are never both 1 on the same line.
- R7: Bank bits at flat positions at or above `NUM_LINES` have no effect on any output.
- R8: The outputs follow the inputs combinationally. A change to any input is visible on the outputs in the same clock cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| route_gate | input | 1 | Global gate; 0 forces every output-enable low |
| cfg_line_en | input | NUM_BANKS*BANK_W | Enable banks, flat; 1 = line active, 0 = high-impedance |
| cfg_line_dir | input | NUM_BANKS*BANK_W | Direction banks, flat; 0 = SoC drives header, 1 = header drives SoC |
| soc_tx | input | NUM_LINES | Data driven by the SoC toward the header |
| soc_rx | output | NUM_LINES | Data presented to the SoC from the header |
| soc_rx_oe | output | NUM_LINES | Drive enable on the SoC side |
| hdr_rx | input | NUM_LINES | Data read from the header pins |
| hdr_tx | output | NUM_LINES | Data driven onto the header pins |
| hdr_tx_oe | output | NUM_LINES | Drive enable on the header side |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies on any path. The bench changes inputs only on a rising clock edge and reads the outputs on the following falling edge, half a period later. A missing or extra register stage would therefore show up as a stale value. The line count is set to 40, so the last eight bits of the third bank exercise the ignored positions. The sweeps are a walk of a single enable bit through every flat position, fixed patterns for each combination of gate, enable and direction, and a pseudo-random run.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

  // Per-line control pair, extracted from the two register banks
  typedef struct packed {
    logic active;   // 1 = line driven, 0 = high-impedance
    logic from_hdr; // 1 = header drives toward SoC, 0 = SoC drives header
  } line_ctl_t;

  function automatic int banks_for(input int lines, input int bank_w);
    return (lines + bank_w - 1) / bank_w;
  endfunction

endpackage

// File: rtl/io_cfg_slicer.sv
module io_cfg_slicer
  import io_route_pkg::*;
#(
  parameter int NUM_LINES = 48,
  parameter int BANK_W    = 16,
  localparam int NUM_BANKS = banks_for(NUM_LINES, BANK_W),
  localparam int CFG_W     = NUM_BANKS * BANK_W
) (
  input  logic [CFG_W-1:0]  en_banks,
  input  logic [CFG_W-1:0]  dir_banks,
  output line_ctl_t         ctl [NUM_LINES]
);

  // Line n sits in bank n/BANK_W at bit n%BANK_W
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int BANK = n / BANK_W;
    localparam int BIT  = n % BANK_W;
    assign ctl[n].active   = en_banks[BANK*BANK_W + BIT];
    assign ctl[n].from_hdr = dir_banks[BANK*BANK_W + BIT];
  end

  // Positions past the last line are not wired to anything
  if (CFG_W > NUM_LINES) begin : g_spare
    logic unused_spare_bits;
    assign unused_spare_bits = ^{en_banks[CFG_W-1:NUM_LINES],
                                 dir_banks[CFG_W-1:NUM_LINES]};
  end

endmodule

// File: rtl/io_line_cell.sv
module io_line_cell
  import io_route_pkg::*;
(
  input  logic      gate,
  input  line_ctl_t ctl,
  input  logic      soc_d,
  input  logic      hdr_d,
  output logic      hdr_q,
  output logic      hdr_q_oe,
  output logic      soc_q,
  output logic      soc_q_oe
);

  logic live;

  always_comb begin
    live     = gate & ctl.active;
    hdr_q_oe = live & ~ctl.from_hdr;
    soc_q_oe = live &  ctl.from_hdr;
    hdr_q    = hdr_q_oe ? soc_d : 1'b0;
    soc_q    = soc_q_oe ? hdr_d : 1'b0;
  end

endmodule

// File: rtl/io_line_router.sv
module io_line_router
  import io_route_pkg::*;
#(
  parameter int NUM_LINES = 48,
  parameter int BANK_W    = 16,
  localparam int NUM_BANKS = banks_for(NUM_LINES, BANK_W),
  localparam int CFG_W     = NUM_BANKS * BANK_W
) (
  input  logic                 route_gate,
  input  logic [CFG_W-1:0]     cfg_line_en,
  input  logic [CFG_W-1:0]     cfg_line_dir,
  input  logic [NUM_LINES-1:0] soc_tx,
  output logic [NUM_LINES-1:0] soc_rx,
  output logic [NUM_LINES-1:0] soc_rx_oe,
  input  logic [NUM_LINES-1:0] hdr_rx,
  output logic [NUM_LINES-1:0] hdr_tx,
  output logic [NUM_LINES-1:0] hdr_tx_oe
);

  line_ctl_t ctl [NUM_LINES];

  io_cfg_slicer #(
    .NUM_LINES (NUM_LINES),
    .BANK_W    (BANK_W)
  ) u_slicer (
    .en_banks  (cfg_line_en),
    .dir_banks (cfg_line_dir),
    .ctl       (ctl)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_cell
    io_line_cell u_cell (
      .gate     (route_gate),
      .ctl      (ctl[n]),
      .soc_d    (soc_tx[n]),
      .hdr_d    (hdr_rx[n]),
      .hdr_q    (hdr_tx[n]),
      .hdr_q_oe (hdr_tx_oe[n]),
      .soc_q    (soc_rx[n]),
      .soc_q_oe (soc_rx_oe[n])
    );
  end

endmodule

// File: rtl/io_line_router_chk.sv
module io_line_router_chk #(
  parameter int NUM_LINES = 48,
  parameter int CFG_W     = 48
) (
  input logic                 route_gate,
  input logic [CFG_W-1:0]     cfg_line_en,
  input logic [CFG_W-1:0]     cfg_line_dir,
  input logic [NUM_LINES-1:0] soc_tx,
  input logic [NUM_LINES-1:0] soc_rx,
  input logic [NUM_LINES-1:0] soc_rx_oe,
  input logic [NUM_LINES-1:0] hdr_rx,
  input logic [NUM_LINES-1:0] hdr_tx,
  input logic [NUM_LINES-1:0] hdr_tx_oe
);

  always_comb begin
    AST_GATE_LOW: assert (route_gate || (hdr_tx_oe == '0 && soc_rx_oe == '0))
      else $error("gate low but a line is driven"); // R4
    AST_EXCLUSIVE_OE: assert ((hdr_tx_oe & soc_rx_oe) == '0)
      else $error("both sides driven on one line"); // R6
    AST_QUIET_DATA: assert ((hdr_tx & ~hdr_tx_oe) == '0 && (soc_rx & ~soc_rx_oe) == '0)
      else $error("data present without drive enable"); // R6
    for (int n = 0; n < NUM_LINES; n++) begin
      AST_TX_PATH: assert (!(route_gate && cfg_line_en[n] && !cfg_line_dir[n]) ||
                           (hdr_tx_oe[n] && hdr_tx[n] == soc_tx[n]))
        else $error("line %0d not routed toward header", n); // R1
      AST_RX_PATH: assert (!(route_gate && cfg_line_en[n] && cfg_line_dir[n]) ||
                           (soc_rx_oe[n] && soc_rx[n] == hdr_rx[n]))
        else $error("line %0d not routed toward SoC", n); // R2
      AST_OFF_QUIET: assert (cfg_line_en[n] || (!hdr_tx_oe[n] && !soc_rx_oe[n]))
        else $error("disabled line %0d driven", n); // R3
    end
  end

endmodule

bind io_line_router io_line_router_chk #(
  .NUM_LINES (NUM_LINES),
  .CFG_W     (CFG_W)
) u_chk (
  .route_gate   (route_gate),
  .cfg_line_en  (cfg_line_en),
  .cfg_line_dir (cfg_line_dir),
  .soc_tx       (soc_tx),
  .soc_rx       (soc_rx),
  .soc_rx_oe    (soc_rx_oe),
  .hdr_rx       (hdr_rx),
  .hdr_tx       (hdr_tx),
  .hdr_tx_oe    (hdr_tx_oe)
);

// File: tb/sim_io_line_router.sv
`timescale 1ns/1ps
module sim_io_line_router;

  localparam int NL    = 40;
  localparam int BW    = 16;
  localparam int CW    = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          route_gate;
  logic [CW-1:0] cfg_line_en, cfg_line_dir;
  logic [NL-1:0] soc_tx, soc_rx, soc_rx_oe, hdr_rx, hdr_tx, hdr_tx_oe;

  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  io_line_router #(.NUM_LINES(NL), .BANK_W(BW)) u0 (
    .route_gate   (route_gate),
    .cfg_line_en  (cfg_line_en),
    .cfg_line_dir (cfg_line_dir),
    .soc_tx       (soc_tx),
    .soc_rx       (soc_rx),
    .soc_rx_oe    (soc_rx_oe),
    .hdr_rx       (hdr_rx),
    .hdr_tx       (hdr_tx),
    .hdr_tx_oe    (hdr_tx_oe)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive on a rising edge, read back half a period later (same cycle, R8)
  task automatic apply(input string req, input logic g,
                       input logic [CW-1:0] en, input logic [CW-1:0] dir,
                       input logic [NL-1:0] stx, input logic [NL-1:0] hrx);
    logic [NL-1:0] e_htx, e_hoe, e_srx, e_soe;
    @(posedge clk);
    route_gate = g; cfg_line_en = en; cfg_line_dir = dir;
    soc_tx = stx; hdr_rx = hrx;
    for (int n = 0; n < NL; n++) begin
      // bank n/BW, bit n%BW (R5)
      int idx = (n / BW) * BW + (n % BW);
      logic on = g & en[idx];
      e_hoe[n] = on & ~dir[idx];
      e_soe[n] = on &  dir[idx];
      e_htx[n] = e_hoe[n] & stx[n];
      e_srx[n] = e_soe[n] & hrx[n];
    end
    @(negedge clk);
    cmp(req, "hdr_tx",    hdr_tx,    e_htx);
    cmp(req, "hdr_tx_oe", hdr_tx_oe, e_hoe);
    cmp(req, "soc_rx",    soc_rx,    e_srx);
    cmp(req, "soc_rx_oe", soc_rx_oe, e_soe);
  endtask

  initial begin
    route_gate = 1'b0; cfg_line_en = '0; cfg_line_dir = '0;
    soc_tx = '0; hdr_rx = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R6: idle state, nothing driven
    apply("R6", 1'b0, '0, '0, '0, '0);

    // R1: all lines SoC to header, several data patterns
    apply("R1", 1'b1, '1, '0, {NL{1'b1}}, '0);
    apply("R1", 1'b1, '1, '0, 40'hA5_5A5A_A5A5, 40'hFF_FFFF_FFFF);
    apply("R1", 1'b1, '1, '0, 40'h12_3456_789A, 40'h0);

    // R2: all lines header to SoC
    apply("R2", 1'b1, '1, '1, 40'hFF_FFFF_FFFF, 40'h3C_C3C3_3CC3);
    apply("R2", 1'b1, '1, '1, 40'h0, {NL{1'b1}});

    // R3: disabled lines stay quiet under any direction
    apply("R3", 1'b1, '0, '1, {NL{1'b1}}, {NL{1'b1}});
    apply("R3", 1'b1, 48'h0000_F0F0_F0F0, 48'h00FF_00FF_00FF, {NL{1'b1}}, {NL{1'b1}});

    // R4: gate low overrides full enable
    apply("R4", 1'b0, '1, '0, {NL{1'b1}}, {NL{1'b1}});
    apply("R4", 1'b0, '1, '1, {NL{1'b1}}, {NL{1'b1}});

    // R5/R7: walk a single enable bit through every flat position,
    // including the spare positions 40..47 of bank 2
    for (int p = 0; p < CW; p++) begin
      logic [CW-1:0] one = '0;
      one[p] = 1'b1;
      apply(p < NL ? "R5" : "R7", 1'b1, one, (p % 2 == 1) ? one : '0,
            {NL{1'b1}}, {NL{1'b1}});
    end

    // R7: spare bits set alone leave every output quiet
    apply("R7", 1'b1, 48'hFF00_0000_0000, 48'hFF00_0000_0000, {NL{1'b1}}, {NL{1'b1}});

    // R8: pseudo-random run, each result read in the cycle it was driven
    for (int k = 0; k < 300; k++) begin
      logic [63:0] a, b, c, d;
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      seed = next_rand(seed); c = seed;
      seed = next_rand(seed); d = seed;
      apply("R8", a[63] | a[62], a[47:0], b[47:0], c[NL-1:0], d[NL-1:0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule